// File: doc/BRIEF.md
# Power Mode Controller

This block selects and tracks the operating power mode of a small microcontroller. Software programs one 8-bit control register and one protection register over a simple register bus. The protection register can be written once after reset, and it decides which low-power modes software may pick. The controller keeps the current mode and reports it as a one-hot status vector. The modes are normal run, very low power run, wait, very low power wait, stop, very low power stop and lowest-leakage stop.

A stop request comes with two qualifiers, deep-sleep and wait. It leads either at once into a wait mode or into a stop-entry sequence. That sequence ends when the clock and power logic acknowledges that it is ready. An interrupt or a reset event that arrives while the sequence is still open cancels the entry, and the block then sets a sticky aborted flag that software can read.

Interrupts wake the block from the wait and stop modes. Where the block returns depends on the mode it left and on a software wake-on-interrupt bit.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the status reports run (bit 0), both registers read 0x00, and the stop-entry request and low-power request outputs are low.
- R2: The control register reads as {wake-on-irq[7], run-select[6:5], 0[4], aborted[3], stop-select[2:0]}. Writes to bits 4 and 3 have no effect. Stop-select codes 001, 011, 101, 110 and 111 are stored as written.
- R3: The protection register uses bit 0 to enable the very-low-power modes and bit 1 to enable the lowest-leakage stop. A write of run-select 10 or stop-select 010 is ignored unless bit 0 is set. A write of stop-select 100 is ignored unless bit 1 is set.
- R4: The protection register takes only its first write after reset. Later writes leave it unchanged.
- R5: Run-select 10 is accepted only while the status is run, and the mode moves to very low power run (bit 1). Run-select 00 is accepted only while the status is very low power run, and the mode moves back to run. The codes 01 and 11 are ignored.
- R6: Run-select reads 00 after every return to run.
- R7: In very low power run, an interrupt returns the mode to run when wake-on-irq is 1. When wake-on-irq is 0 the interrupt has no effect.
- R8: A stop request with deep-sleep set and wait clear raises the stop-entry request on the next cycle. When the acknowledge arrives, the block enters stop (bit 4) for codes other than 010 and 100, very low power stop (bit 5) for 010, and lowest-leakage stop (bit 6) for 100.
- R9: A stop request with wait set enters wait (bit 2) from run, or very low power wait (bit 3) from very low power run, on the next cycle. A stop request with both qualifiers clear is ignored.
- R10: An interrupt in a wait or stop mode returns to run when that mode was entered from run. When it was entered from very low power run, the interrupt returns to run if wake-on-irq is 1 and to very low power run if it is 0.
- R11: The aborted flag clears when a stop entry begins. An interrupt or reset event during the entry ends it without a mode change and sets the flag.
- R12: A reset event forces the mode to run and clears run-select. Outside a stop entry it leaves the aborted flag unchanged.
- R13: Exactly one status bit is set on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 protection |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| stop_req | input | 1 | Sleep request |
| deep_sleep | input | 1 | Deep-sleep qualifier |
| wait_sel | input | 1 | Wait qualifier |
| irq | input | 1 | Any active interrupt |
| reset_evt | input | 1 | Reset event from the system |
| stop_ack | input | 1 | Clock and power logic ready for stop |
| mode_status | output | 7 | One-hot current mode |
| stop_entry_req | output | 1 | Stop-entry sequence in progress |
| vlp_req | output | 1 | Very-low-power mode active |
| stop_aborted | output | 1 | Last stop entry was aborted |

## Verification
A wrong next-mode decision shows on the one-hot status one clock after the stimulus. A wrong origin or wake-on-irq record stays hidden until the next interrupt, and it then shows as the wrong wake target. The bench therefore enters every stop code and the wait mode from both run and very low power run, under both wake-on-irq settings, and follows each entry with a wake.

A corrupted register field shows on the next read. A missed clear of run-select shows one cycle after a return to run, when the status moves straight back to very low power run.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int CTRL_W   = 8;
    localparam int MODE_N   = 7;
    localparam int RUNM_W   = 2;
    localparam int STOPM_W  = 3;
    localparam int PROT_W   = 2;
    localparam int B_WAKE   = 7;
    localparam int RUNM_LSB = 5;
    localparam int B_ABORT  = 3;

    localparam logic [RUNM_W-1:0]  RUNM_NORM  = 2'b00;
    localparam logic [RUNM_W-1:0]  RUNM_VLP   = 2'b10;
    localparam logic [STOPM_W-1:0] STOPM_VLPS = 3'b010;
    localparam logic [STOPM_W-1:0] STOPM_LLS  = 3'b100;

    typedef enum logic [2:0] {
        MD_RUN  = 3'd0,
        MD_VLPR = 3'd1,
        MD_WAIT = 3'd2,
        MD_VLPW = 3'd3,
        MD_STOP = 3'd4,
        MD_VLPS = 3'd5,
        MD_LLS  = 3'd6
    } mode_e;

    function automatic mode_e stop_target(input logic [STOPM_W-1:0] code);
        if (code == STOPM_VLPS)     return MD_VLPS;
        else if (code == STOPM_LLS) return MD_LLS;
        else                        return MD_STOP;
    endfunction
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
    import pmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic               bus_sel,
    input  logic [CTRL_W-1:0]  bus_wdata,
    output logic [CTRL_W-1:0]  bus_rdata,
    input  mode_e              cur_mode,
    input  logic               busy,
    input  logic               clr_runm,
    input  logic               abort_set,
    input  logic               abort_clr,
    output logic               wake_irq,
    output logic [RUNM_W-1:0]  runm,
    output logic [STOPM_W-1:0] stopm,
    output logic               aborted
);
    typedef struct packed {
        logic               wake;
        logic [RUNM_W-1:0]  runm;
        logic [STOPM_W-1:0] stopm;
        logic               abort;
        logic [PROT_W-1:0]  prot;
        logic               lock;
    } regs_t;

    regs_t q, d;
    logic [RUNM_W-1:0]  wr_runm;
    logic [STOPM_W-1:0] wr_stopm;
    logic               runm_ok, stopm_ok;
    logic [PROT_W-1:0]  prot_q;
    logic               lock_q;

    assign wr_runm  = bus_wdata[RUNM_LSB +: RUNM_W];
    assign wr_stopm = bus_wdata[STOPM_W-1:0];
    assign runm_ok  = !busy &&
                      ((wr_runm == RUNM_VLP && cur_mode == MD_RUN && q.prot[0]) ||
                       (wr_runm == RUNM_NORM && cur_mode == MD_VLPR));
    assign stopm_ok = (wr_stopm != STOPM_VLPS || q.prot[0]) &&
                      (wr_stopm != STOPM_LLS  || q.prot[1]);

    always_comb begin
        d = q;
        if (bus_we && !bus_sel) begin
            d.wake = bus_wdata[B_WAKE];
            if (runm_ok)  d.runm  = wr_runm;
            if (stopm_ok) d.stopm = wr_stopm;
        end
        if (bus_we && bus_sel && !q.lock) begin
            d.prot = bus_wdata[PROT_W-1:0];
            d.lock = 1'b1;
        end
        if (clr_runm)  d.runm  = RUNM_NORM;
        if (abort_clr) d.abort = 1'b0;
        if (abort_set) d.abort = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (bus_sel) bus_rdata = {{(CTRL_W-PROT_W){1'b0}}, q.prot};
        else         bus_rdata = {q.wake, q.runm, 1'b0, q.abort, q.stopm};
    end

    assign wake_irq = q.wake;
    assign runm     = q.runm;
    assign stopm    = q.stopm;
    assign aborted  = q.abort;
    assign prot_q   = q.prot;
    assign lock_q   = q.lock;

    // R3
    no_vlp_runm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_q[0] |-> runm != RUNM_VLP);
    // R4
    prot_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> prot_q == $past(prot_q));
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop_req,
    input  logic               deep_sleep,
    input  logic               wait_sel,
    input  logic               irq,
    input  logic               reset_evt,
    input  logic               stop_ack,
    input  logic               wake_irq,
    input  logic [RUNM_W-1:0]  runm,
    input  logic [STOPM_W-1:0] stopm,
    output mode_e              mode,
    output logic               entering,
    output logic               clr_runm,
    output logic               abort_set,
    output logic               abort_clr,
    output logic [MODE_N-1:0]  mode_status
);
    typedef struct packed {
        mode_e mode;
        logic  entering;
        mode_e tgt;
        logic  from_run;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d         = q;
        clr_runm  = 1'b0;
        abort_set = 1'b0;
        abort_clr = 1'b0;
        if (reset_evt) begin
            d.mode     = MD_RUN;
            d.entering = 1'b0;
            clr_runm   = 1'b1;
            abort_set  = q.entering;
        end else if (q.entering) begin
            if (irq) begin
                d.entering = 1'b0;
                abort_set  = 1'b1;
            end else if (stop_ack) begin
                d.entering = 1'b0;
                d.mode     = q.tgt;
            end
        end else begin
            unique case (q.mode)
                MD_RUN, MD_VLPR: begin
                    if (q.mode == MD_VLPR && irq && wake_irq) begin
                        d.mode   = MD_RUN;
                        clr_runm = 1'b1;
                    end else if (stop_req && wait_sel) begin
                        d.mode     = (q.mode == MD_RUN) ? MD_WAIT : MD_VLPW;
                        d.from_run = (q.mode == MD_RUN);
                    end else if (stop_req && deep_sleep) begin
                        d.entering = 1'b1;
                        abort_clr  = 1'b1;
                        d.tgt      = stop_target(stopm);
                        d.from_run = (q.mode == MD_RUN);
                    end else if (q.mode == MD_RUN && runm == RUNM_VLP) begin
                        d.mode = MD_VLPR;
                    end else if (q.mode == MD_VLPR && runm == RUNM_NORM) begin
                        d.mode = MD_RUN;
                    end
                end
                default: begin
                    if (irq) begin
                        if (q.from_run || wake_irq) begin
                            d.mode   = MD_RUN;
                            clr_runm = 1'b1;
                        end else begin
                            d.mode = MD_VLPR;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{mode: MD_RUN, entering: 1'b0, tgt: MD_STOP, from_run: 1'b1};
        else        q <= d;
    end

    assign mode        = q.mode;
    assign entering    = q.entering;
    assign mode_status = MODE_N'(1) << q.mode;

    // R8
    entry_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entering |-> (mode == MD_RUN || mode == MD_VLPR));
    // R8
    stop_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entering && stop_ack && !irq && !reset_evt |=>
        (mode == MD_STOP || mode == MD_VLPS || mode == MD_LLS));
    // R11
    abort_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entering && irq && !reset_evt |=> !entering && mode == $past(mode));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_sel,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              stop_req,
    input  logic              deep_sleep,
    input  logic              wait_sel,
    input  logic              irq,
    input  logic              reset_evt,
    input  logic              stop_ack,
    output logic [6:0]        mode_status,
    output logic              stop_entry_req,
    output logic              vlp_req,
    output logic              stop_aborted
);
    mode_e               mode;
    logic                entering, clr_runm, abort_set, abort_clr, wake_irq;
    logic [RUNM_W-1:0]   runm;
    logic [STOPM_W-1:0]  stopm;

    pmc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cur_mode  (mode),
        .busy      (entering),
        .clr_runm  (clr_runm),
        .abort_set (abort_set),
        .abort_clr (abort_clr),
        .wake_irq  (wake_irq),
        .runm      (runm),
        .stopm     (stopm),
        .aborted   (stop_aborted)
    );

    pmc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .deep_sleep  (deep_sleep),
        .wait_sel    (wait_sel),
        .irq         (irq),
        .reset_evt   (reset_evt),
        .stop_ack    (stop_ack),
        .wake_irq    (wake_irq),
        .runm        (runm),
        .stopm       (stopm),
        .mode        (mode),
        .entering    (entering),
        .clr_runm    (clr_runm),
        .abort_set   (abort_set),
        .abort_clr   (abort_clr),
        .mode_status (mode_status)
    );

    assign stop_entry_req = entering;
    assign vlp_req        = (mode == MD_VLPR) || (mode == MD_VLPW) || (mode == MD_VLPS);

    // R13
    onehot_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_status) == 1);
    // R6
    runm_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RUN) && ($past(mode) != MD_RUN) |-> runm == RUNM_NORM);
    // R11
    abort_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_aborted) |-> $past(entering));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/100ps
module test_pwr_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0, bus_sel = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       stop_req = 1'b0, deep_sleep = 1'b0, wait_sel = 1'b0;
    logic       irq = 1'b0, reset_evt = 1'b0, stop_ack = 1'b0;
    logic [6:0] mode_status;
    logic       stop_entry_req, vlp_req, stop_aborted;
    int         n_chk = 0, n_fail = 0;

    pwr_mode_ctrl i_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_req(stop_req),
        .deep_sleep(deep_sleep), .wait_sel(wait_sel), .irq(irq),
        .reset_evt(reset_evt), .stop_ack(stop_ack), .mode_status(mode_status),
        .stop_entry_req(stop_entry_req), .vlp_req(vlp_req),
        .stop_aborted(stop_aborted)
    );

    always #2 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] dat);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = dat;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        bus_sel = sel;
        #0.2;
        v = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
    endtask

    task automatic pulse_irq();
        irq = 1'b1; step(); irq = 1'b0;
    endtask

    function automatic logic [7:0] oh(input int idx);
        return 8'(1) << idx;
    endfunction

    function automatic int stop_idx(input logic [2:0] code);
        return (code == 3'b010) ? 5 : (code == 3'b100) ? 6 : 4;
    endfunction

    task automatic enter_stop(input logic [2:0] code, input string tag);
        stop_req = 1'b1; deep_sleep = 1'b1; wait_sel = 1'b0;
        step();
        stop_req = 1'b0; deep_sleep = 1'b0;
        chk({tag, " R8 entry request"}, {7'b0, stop_entry_req}, 8'h01);
        chk({tag, " R11 flag cleared at entry"}, {7'b0, stop_aborted}, 8'h00);
        stop_ack = 1'b1; step(); stop_ack = 1'b0;
        chk({tag, " R8 stop mode"}, {1'b0, mode_status}, oh(stop_idx(code)));
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        do_reset();
        // R1 reset state
        chk("R1 status", {1'b0, mode_status}, 8'h01);
        rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
        rd(1'b1, v); chk("R1 prot", v, 8'h00);
        chk("R1 outputs", {6'b0, stop_entry_req, vlp_req}, 8'h00);

        // R3 writes gated while protection is clear
        wr(1'b0, 8'h40); step();
        rd(1'b0, v); chk("R3 runm blocked", v, 8'h00);
        chk("R3 still run", {1'b0, mode_status}, 8'h01);
        wr(1'b0, 8'h02); rd(1'b0, v); chk("R3 vlps blocked", v, 8'h00);
        wr(1'b0, 8'h04); rd(1'b0, v); chk("R3 lls blocked", v, 8'h00);
        // R2 layout, reserved and status bits ignore writes
        wr(1'b0, 8'hFF); rd(1'b0, v); chk("R2 layout", v, 8'h87);
        wr(1'b0, 8'h00);

        // R4 write-once protection
        wr(1'b1, 8'h01); rd(1'b1, v); chk("R4 first write", v, 8'h01);
        wr(1'b1, 8'h03); rd(1'b1, v); chk("R4 second write ignored", v, 8'h01);
        wr(1'b0, 8'h04); rd(1'b0, v); chk("R3 lls still blocked", v, 8'h00);
        wr(1'b0, 8'h02); rd(1'b0, v); chk("R3 vlps enabled", v, 8'h02);

        do_reset();
        wr(1'b1, 8'h03);

        // R8 R10 every stop code from run, both wake settings
        for (int lp = 0; lp < 2; lp++) begin
            for (int c = 0; c < 8; c++) begin
                logic [7:0] w;
                w = 8'(lp << 7) | 8'(c);
                wr(1'b0, w);
                rd(1'b0, v); chk("R2 stop code readback", v, w);
                enter_stop(3'(c), "from run");
                pulse_irq();
                chk("R10 wake from run origin", {1'b0, mode_status}, 8'h01);
            end
        end

        // R5 enter very low power run
        wr(1'b0, 8'h40); step();
        chk("R5 vlpr entered", {1'b0, mode_status}, 8'h02);
        chk("R5 vlp request", {7'b0, vlp_req}, 8'h01);
        rd(1'b0, v); chk("R5 runm readback", v, 8'h40);
        // R7 interrupt with wake bit clear
        pulse_irq(); step();
        chk("R7 stays vlpr", {1'b0, mode_status}, 8'h02);
        wr(1'b0, 8'hC0);
        pulse_irq();
        chk("R7 wake to run", {1'b0, mode_status}, 8'h01);
        rd(1'b0, v); chk("R6 runm cleared", v, 8'h80);
        step();
        chk("R6 no re-entry", {1'b0, mode_status}, 8'h01);

        // R9 R10 entries from very low power run
        for (int lp = 0; lp < 2; lp++) begin
            for (int k = 0; k < 4; k++) begin
                logic [2:0] code;
                code = (k == 2) ? 3'b010 : (k == 3) ? 3'b100 : 3'b000;
                wr(1'b0, 8'(lp << 7) | 8'h40 | 8'(code));
                step();
                chk("R5 vlpr before entry", {1'b0, mode_status}, 8'h02);
                if (k == 0) begin
                    stop_req = 1'b1; wait_sel = 1'b1;
                    step();
                    stop_req = 1'b0; wait_sel = 1'b0;
                    chk("R9 vlp wait", {1'b0, mode_status}, 8'h08);
                end else begin
                    enter_stop(code, "from vlpr");
                end
                pulse_irq();
                chk("R10 wake target", {1'b0, mode_status}, (lp == 1) ? 8'h01 : 8'h02);
                rd(1'b0, v);
                chk("R6 runm after wake", v, 8'(lp << 7) | ((lp == 1) ? 8'h00 : 8'h40) | 8'(code));
            end
        end

        // R5 back to run by write, reserved codes ignored
        wr(1'b0, 8'h40); step();
        wr(1'b0, 8'h00); step();
        chk("R5 back to run", {1'b0, mode_status}, 8'h01);
        rd(1'b0, v); chk("R5 runm zero", v, 8'h00);
        wr(1'b0, 8'h20); step();
        rd(1'b0, v); chk("R5 code 01 ignored", v, 8'h00);
        wr(1'b0, 8'h60); step();
        rd(1'b0, v); chk("R5 code 11 ignored", v, 8'h00);
        chk("R5 run kept", {1'b0, mode_status}, 8'h01);

        // R9 unqualified request ignored, wait from run
        stop_req = 1'b1; step(); stop_req = 1'b0;
        chk("R9 no entry", {7'b0, stop_entry_req}, 8'h00);
        chk("R9 run kept", {1'b0, mode_status}, 8'h01);
        stop_req = 1'b1; wait_sel = 1'b1; step(); stop_req = 1'b0; wait_sel = 1'b0;
        chk("R9 wait from run", {1'b0, mode_status}, 8'h04);
        pulse_irq();
        chk("R10 wait wake", {1'b0, mode_status}, 8'h01);

        // R11 abort by interrupt
        stop_req = 1'b1; deep_sleep = 1'b1; step(); stop_req = 1'b0; deep_sleep = 1'b0;
        chk("R11 entry open", {7'b0, stop_entry_req}, 8'h01);
        pulse_irq();
        chk("R11 mode kept", {1'b0, mode_status}, 8'h01);
        chk("R11 entry closed", {7'b0, stop_entry_req}, 8'h00);
        rd(1'b0, v); chk("R11 flag set", v & 8'h08, 8'h08);
        stop_ack = 1'b1; step(); stop_ack = 1'b0;
        chk("R11 late ack ignored", {1'b0, mode_status}, 8'h01);
        // R11 flag clears on next entry, R12 reset event aborts even with ack
        stop_req = 1'b1; deep_sleep = 1'b1; step(); stop_req = 1'b0; deep_sleep = 1'b0;
        chk("R11 flag cleared", {7'b0, stop_aborted}, 8'h00);
        stop_ack = 1'b1; reset_evt = 1'b1; step(); stop_ack = 1'b0; reset_evt = 1'b0;
        chk("R12 abort mode", {1'b0, mode_status}, 8'h01);
        chk("R11 reset abort flag", {7'b0, stop_aborted}, 8'h01);

        // R12 reset event outside entry
        enter_stop(3'b000, "clean");
        pulse_irq();
        wr(1'b0, 8'h40); step();
        chk("R12 vlpr first", {1'b0, mode_status}, 8'h02);
        reset_evt = 1'b1; step(); reset_evt = 1'b0;
        chk("R12 forced run", {1'b0, mode_status}, 8'h01);
        rd(1'b0, v); chk("R12 runm and flag", v, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule